// File: doc/BRIEF.md
# Split Completion Data Error Responder

This block sits beside the target side of a split-transaction bus interface and reacts to uncorrectable data errors found while a split completion message is being accepted. The bus side keeps running: the data is taken and the transfer ends normally. This block only decides what is signalled about the error and when.

For each errored data phase, the block starts a delayed, active-low parity-error pulse and, when escalation is allowed, a matching active-low system-error pulse. It records the event in sticky status bits and in a second bank of interrupt status bits. Each interrupt status bit has its own mask, except the system-error-detected bit, which has an enable instead. It also flags the affected transaction for discard and, when that transaction was a read, asks the internal bus to abort the read completion. Software clears both banks with write-one-to-clear writes, and a single interrupt line reports whether any interrupt status bit is set.

Top module: `split_err_responder`

## Requirements
- R1: After synchronous reset, `perr_n` and `serr_n` are high, both status banks are zero, and `irq`, `discard` and `rd_abort` are low.
- R2: For an errored data phase sampled at clock edge t (`dphase_valid` and `dphase_err` both 1) while `ctl_perr_resp` is 1, `perr_n` is low for exactly one clock, starting after edge t+2 (the third cycle after the data phase). When `ctl_perr_resp` is 0 at edge t, there is no pulse.
- R3: Errored data phases in consecutive cycles each produce their own one-clock `perr_n` pulse, so the pulses are back to back.
- R4: `serr_n` is low in the same clock as the `perr_n` pulse, and only when `ctl_serr_en` was 1 and `ctl_recov_en` was 0 at edge t.
- R5: Status bit 0 (master parity error) is set at the same edge at which `perr_n` goes low. Status bit 1 (system error asserted) is set at the same edge at which `serr_n` goes low.
- R6: Status bit 3 (detected parity error) is set at edge t for every errored data phase, whatever the control bits are.
- R7: Status bit 2 (received split completion error) is set at the edge at which `attr_valid` is 1 and `attr_word[30]` is 1. The other bits of the attribute word have no effect.
- R8: Interrupt status bits 0 to 3 are set by the same events, at the same edges, as status bits 0 to 3, but only when `irq_mask` bit i is 0. Interrupt status bit 4 (system error detected) is set with status bit 1 only when `serr_det_ie` is 1.
- R9: `discard` is a one-clock pulse after edge t for every errored data phase. `rd_abort` pulses in the same clock only when `txn_is_read` was 1 at edge t.
- R10: A clock with `wr_en` set clears every bit whose `wr_data` bit is 1, in the status bank when `wr_sel` is 0 and in the interrupt status bank when `wr_sel` is 1. `wr_data` bits that are 0 leave their bits unchanged.
- R11: `irq` is high exactly when at least one interrupt status bit is set.
- R12: `dphase_err` has no effect while `dphase_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dphase_valid | input | 1 | Data phase of a claimed split completion |
| dphase_err | input | 1 | Uncorrectable data error in this data phase |
| txn_is_read | input | 1 | Transaction being completed is a read |
| attr_valid | input | 1 | Attribute phase strobe |
| attr_word | input | 32 | Completer attribute word |
| ctl_perr_resp | input | 1 | Parity error response enable |
| ctl_serr_en | input | 1 | System error enable |
| ctl_recov_en | input | 1 | Data error recovery enable (blocks system error) |
| irq_mask | input | 4 | Masks for interrupt status bits 0 to 3 |
| serr_det_ie | input | 1 | Enable for interrupt status bit 4 |
| wr_en | input | 1 | Write-one-to-clear strobe |
| wr_sel | input | 1 | 0 selects the status bank, 1 the interrupt status bank |
| wr_data | input | 5 | Bits to clear |
| perr_n | output | 1 | Active-low parity error pulse |
| serr_n | output | 1 | Active-low system error pulse |
| status | output | 4 | Sticky status bits |
| irq_status | output | 5 | Sticky interrupt status bits |
| irq | output | 1 | OR of all interrupt status bits |
| discard | output | 1 | Discard pulse for the errored transaction |
| rd_abort | output | 1 | Internal read completion abort pulse |

## Verification
The bench sweeps all eight combinations of the three control bits against all sixteen mask values. A design with the escalation gate inverted, or with a mask bit confused with the detected-interrupt enable, would set the wrong status or interrupt bits in some of these trials. The bench times the parity pulse against the errored phase and sends two errors back to back. An off-by-one delay or a pipeline that merges the events would shift the pulse or leave only one low clock. It also checks that write-zero leaves bits set, that the attribute bit is decoded at position 30 only, and that an error flag without a valid data phase is ignored.

// File: rtl/spe_pkg.sv
package spe_pkg;
  localparam int STS_W   = 4;
  localparam int IRQ_W   = 5;
  localparam int SCE_BIT = 30;
  localparam int B_MPE   = 0;
  localparam int B_SERR  = 1;
  localparam int B_RXSCE = 2;
  localparam int B_DPE   = 3;
  localparam int B_SDET  = 4;

  typedef struct packed {
    logic perr;
    logic serr;
  } err_tag_t;
endpackage

// File: rtl/err_delay_pipe.sv
module err_delay_pipe
  import spe_pkg::*;
#(
  parameter int DELAY = 3
) (
  input  logic     clk,
  input  logic     rst,
  input  err_tag_t tag_in,
  output err_tag_t tag_tail,
  output logic     perr_n,
  output logic     serr_n
);
  localparam int STAGES = DELAY - 1;

  err_tag_t stage_q [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= '0;
          else     stage_q[0] <= tag_in;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (rst) stage_q[i] <= '0;
          else     stage_q[i] <= stage_q[i-1];
        end
      end
    end
  endgenerate

  assign tag_tail = stage_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      perr_n <= 1'b1;
      serr_n <= 1'b1;
    end else begin
      perr_n <= ~tag_tail.perr;
      serr_n <= ~tag_tail.serr;
    end
  end

  // R2
  perr_follows_tail_chk: assert property (@(posedge clk) disable iff (rst)
    tag_tail.perr |=> !perr_n);
  // R2
  perr_single_chk: assert property (@(posedge clk) disable iff (rst)
    !tag_tail.perr |=> perr_n);
  // R4
  serr_with_perr_chk: assert property (@(posedge clk) disable iff (rst)
    !serr_n |-> !perr_n);
endmodule

// File: rtl/sticky_bank.sv
module sticky_bank #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q & ~clr_vec) | set_vec;
  end

  // R10
  set_sticks_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((q & $past(set_vec)) == $past(set_vec)));
  // R10
  untouched_hold_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((q & ~$past(clr_vec)) == (($past(q) | $past(set_vec)) & ~$past(clr_vec))));
endmodule

// File: rtl/split_err_responder.sv
module split_err_responder
  import spe_pkg::*;
#(
  parameter int DELAY  = 3,
  parameter int ATTR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dphase_valid,
  input  logic              dphase_err,
  input  logic              txn_is_read,
  input  logic              attr_valid,
  input  logic [ATTR_W-1:0] attr_word,
  input  logic              ctl_perr_resp,
  input  logic              ctl_serr_en,
  input  logic              ctl_recov_en,
  input  logic [STS_W-1:0]  irq_mask,
  input  logic              serr_det_ie,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [IRQ_W-1:0]  wr_data,
  output logic              perr_n,
  output logic              serr_n,
  output logic [STS_W-1:0]  status,
  output logic [IRQ_W-1:0]  irq_status,
  output logic              irq,
  output logic              discard,
  output logic              rd_abort
);
  logic             err_evt;
  logic             sce_evt;
  err_tag_t         tag_in;
  err_tag_t         tag_tail;
  logic [STS_W-1:0] sts_set;
  logic [STS_W-1:0] sts_clr;
  logic [IRQ_W-1:0] irq_set;
  logic [IRQ_W-1:0] irq_clr;

  assign err_evt = dphase_valid & dphase_err;
  assign sce_evt = attr_valid & attr_word[SCE_BIT];

  always_comb begin
    tag_in.perr = err_evt & ctl_perr_resp;
    tag_in.serr = err_evt & ctl_perr_resp & ctl_serr_en & ~ctl_recov_en;
  end

  err_delay_pipe #(.DELAY(DELAY)) u_pipe (
    .clk(clk), .rst(rst), .tag_in(tag_in), .tag_tail(tag_tail),
    .perr_n(perr_n), .serr_n(serr_n)
  );

  always_comb begin
    sts_set          = '0;
    sts_set[B_MPE]   = tag_tail.perr;
    sts_set[B_SERR]  = tag_tail.serr;
    sts_set[B_RXSCE] = sce_evt;
    sts_set[B_DPE]   = err_evt;
    irq_set              = {1'b0, sts_set & ~irq_mask};
    irq_set[B_SDET]      = tag_tail.serr & serr_det_ie;
    sts_clr = (wr_en && !wr_sel) ? wr_data[STS_W-1:0] : '0;
    irq_clr = (wr_en &&  wr_sel) ? wr_data : '0;
  end

  sticky_bank #(.W(STS_W)) u_sts (
    .clk(clk), .rst(rst), .set_vec(sts_set), .clr_vec(sts_clr), .q(status)
  );

  sticky_bank #(.W(IRQ_W)) u_irq (
    .clk(clk), .rst(rst), .set_vec(irq_set), .clr_vec(irq_clr), .q(irq_status)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq      <= 1'b0;
      discard  <= 1'b0;
      rd_abort <= 1'b0;
    end else begin
      irq      <= |((irq_status & ~irq_clr) | irq_set);
      discard  <= err_evt;
      rd_abort <= err_evt & txn_is_read;
    end
  end

  // R11
  irq_matches_bank_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (irq_status != '0));
  // R9
  abort_needs_discard_chk: assert property (@(posedge clk) disable iff (rst)
    rd_abort |-> discard);
  // R5
  mpe_with_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !perr_n |-> status[B_MPE]);
  // R5
  serr_sts_with_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !serr_n |-> status[B_SERR]);
  // R6
  dpe_after_err_chk: assert property (@(posedge clk) disable iff (rst)
    discard |-> status[B_DPE]);
endmodule

// File: tb/test_split_err_responder.sv
module test_split_err_responder;
  logic        clk = 1'b0;
  logic        rst;
  logic        dphase_valid, dphase_err, txn_is_read, attr_valid;
  logic [31:0] attr_word;
  logic        ctl_perr_resp, ctl_serr_en, ctl_recov_en, serr_det_ie;
  logic [3:0]  irq_mask;
  logic        wr_en, wr_sel;
  logic [4:0]  wr_data;
  logic        perr_n, serr_n, irq, discard, rd_abort;
  logic [3:0]  status;
  logic [4:0]  irq_status;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  split_err_responder i_split_err_responder (
    .clk(clk), .rst(rst), .dphase_valid(dphase_valid), .dphase_err(dphase_err),
    .txn_is_read(txn_is_read), .attr_valid(attr_valid), .attr_word(attr_word),
    .ctl_perr_resp(ctl_perr_resp), .ctl_serr_en(ctl_serr_en),
    .ctl_recov_en(ctl_recov_en), .irq_mask(irq_mask), .serr_det_ie(serr_det_ie),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .perr_n(perr_n),
    .serr_n(serr_n), .status(status), .irq_status(irq_status), .irq(irq),
    .discard(discard), .rd_abort(rd_abort)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = 5'h1f;
    @(negedge clk);
    wr_sel = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  // one errored data phase, checks the full response (R2 R4 R5 R6 R8 R9 R11)
  task automatic one_error(input logic [2:0] cfg, input logic [3:0] msk,
                           input logic ie, input logic rd);
    logic ep, es;
    logic [3:0] exp_s;
    logic [4:0] exp_i;
    ctl_perr_resp = cfg[0]; ctl_serr_en = cfg[1]; ctl_recov_en = cfg[2];
    irq_mask = msk; serr_det_ie = ie;
    ep = cfg[0];
    es = cfg[0] & cfg[1] & ~cfg[2];
    exp_s = {1'b1, 1'b0, es, ep};
    exp_i = {es & ie, exp_s & ~msk};
    @(negedge clk);
    dphase_valid = 1'b1; dphase_err = 1'b1; txn_is_read = rd;
    @(negedge clk);
    dphase_valid = 1'b0; dphase_err = 1'b0; txn_is_read = 1'b0;
    chk("R9 discard", discard, 1);
    chk("R9 rd_abort", rd_abort, rd);
    chk("R6 dpe", status[3], 1);
    chk("R2 early", perr_n, 1);
    @(negedge clk);
    chk("R2 early2", perr_n, 1);
    chk("R9 one clock", discard, 0);
    @(negedge clk);
    chk("R2 perr_n", perr_n, !ep);
    chk("R4 serr_n", serr_n, !es);
    chk("R5 status", status, exp_s);
    chk("R8 irq_status", irq_status, exp_i);
    chk("R11 irq", irq, exp_i != 0);
    @(negedge clk);
    chk("R2 one clock", perr_n, 1);
    chk("R4 one clock", serr_n, 1);
    clear_all();
    chk("R10 cleared", {irq_status, status}, 0);
    chk("R11 irq clear", irq, 0);
  endtask

  initial begin
    #1500000;
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1;
    dphase_valid = 0; dphase_err = 0; txn_is_read = 0; attr_valid = 0;
    attr_word = '0; ctl_perr_resp = 0; ctl_serr_en = 0; ctl_recov_en = 0;
    irq_mask = '0; serr_det_ie = 0; wr_en = 0; wr_sel = 0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk("R1 perr_n", perr_n, 1);
    chk("R1 serr_n", serr_n, 1);
    chk("R1 banks", {irq_status, status}, 0);
    chk("R1 pulses", {irq, discard, rd_abort}, 0);

    for (int c = 0; c < 8; c++)
      for (int m = 0; m < 16; m++)
        one_error(c[2:0], m[3:0], c[0] ^ m[1], m[0]);

    // R12: error flag without valid phase
    ctl_perr_resp = 1; ctl_serr_en = 1; ctl_recov_en = 0; irq_mask = 0; serr_det_ie = 1;
    @(negedge clk);
    dphase_err = 1'b1; txn_is_read = 1'b1;
    @(negedge clk);
    dphase_err = 1'b0; txn_is_read = 1'b0;
    chk("R12 no discard", discard, 0);
    repeat (3) @(negedge clk);
    chk("R12 no pulse", {perr_n, serr_n}, 2'b11);
    chk("R12 banks", {irq_status, status}, 0);

    // R3: two consecutive errored phases
    @(negedge clk);
    dphase_valid = 1; dphase_err = 1;
    @(negedge clk);
    @(negedge clk);
    dphase_valid = 0; dphase_err = 0;
    @(negedge clk);
    chk("R3 first", perr_n, 0);
    @(negedge clk);
    chk("R3 second", perr_n, 0);
    chk("R3 second serr", serr_n, 0);
    @(negedge clk);
    chk("R3 end", perr_n, 1);

    // R10: write zeros leave bits set, partial clear
    @(negedge clk);
    wr_en = 1; wr_sel = 0; wr_data = 5'h00;
    @(negedge clk);
    chk("R10 write0 status", status, 4'b1011);
    wr_sel = 1;
    @(negedge clk);
    chk("R10 write0 irq", irq_status, 5'b11011);
    wr_data = 5'b00011;
    @(negedge clk);
    wr_en = 0; wr_data = 0;
    chk("R10 partial irq", irq_status, 5'b11000);
    chk("R10 status kept", status, 4'b1011);
    clear_all();

    // R7: attribute bit 30 only
    irq_mask = 4'b0000;
    @(negedge clk);
    attr_valid = 1; attr_word = ~(32'h1 << 30);
    @(negedge clk);
    chk("R7 other bits", status[2], 0);
    attr_word = 32'h1 << 30; attr_valid = 0;
    @(negedge clk);
    chk("R7 no strobe", status[2], 0);
    attr_valid = 1;
    @(negedge clk);
    attr_valid = 0;
    chk("R7 set", status, 4'b0100);
    chk("R8 rxsce irq", irq_status, 5'b00100);
    clear_all();
    irq_mask = 4'b0100;
    @(negedge clk);
    attr_valid = 1;
    @(negedge clk);
    attr_valid = 0;
    chk("R8 rxsce masked", irq_status, 0);
    chk("R7 set masked", status[2], 1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule